// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. Software sets a start strobe. The block then derives a conversion tick from the system clock, or from a separate free-running clock, and runs ten binary-search trials, most significant bit first. On each trial it drives a trial code to an external DAC and takes one comparator decision back. At the end it latches the 10-bit result and presents it as a high byte and a low byte. A format input selects whether the result is placed toward the top or toward the bottom of that byte pair.

Completion clears the busy/go indication and sets a sticky done flag. The flag raises an interrupt when interrupts are enabled. Software can abort a conversion that is running, and the stored result is then left as it was. After every conversion, finished or aborted, the block stays quiet for two conversion ticks. It then drops back into acquisition (tracking) on its own. A start request that arrives during the quiet time is kept and is acted on when that time ends.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, go_o=0, done_flag_o=0, sample_o=1, and both result bytes read 0.
- R2: A one-cycle go_set_i pulse while idle makes go_o=1 and sample_o=0 in the next cycle.
- R3: With clk_sel_i not ending in binary 11, the conversion tick period in system clocks is: 000 gives 2, 100 gives 4, 001 gives 8, 101 gives 16, 010 gives 32, 110 gives 64. go_o stays high for exactly 10 tick periods.
- R4: With clk_sel_i[1:0]=11, ticks come from rising edges of int_clk_i, passed through a two-flop synchronizer.
- R5: The trials run MSB first. Each trial sets its bit in dac_code_o and keeps it only when cmp_i=1, meaning the input is at or above the DAC level. With an ideal comparator the result equals the input code.
- R6: At normal completion, go_o falls, done_flag_o rises, and irq_o equals done_flag_o AND irq_en_i.
- R7: done_flag_o stays set until a flag_clr_i strobe, which clears it in the next cycle.
- R8: A go_clr_i pulse during a conversion aborts it. go_o falls, the result bytes keep their previous value, and done_flag_o is not set.
- R9: After any conversion, sample_o stays 0 for two conversion ticks (exactly 2 tick periods after a completion), then returns to 1 without any further input.
- R10: A go_set_i pulse during the quiet period keeps go_o=1. A new conversion starts when the period ends and completes normally.
- R11: With right_just_i=0, res_hi_o holds result bits 9..2, res_lo_o[7:6] holds bits 1..0, and res_lo_o[5:0]=0.
- R12: With right_just_i=1, res_lo_o holds result bits 7..0, res_hi_o[1:0] holds bits 9..8, and res_hi_o[7:2]=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_set_i | input | 1 | Software write of 1 to the go bit (start) |
| go_clr_i | input | 1 | Software write of 0 to the go bit (abort) |
| clk_sel_i | input | 3 | Conversion clock select |
| right_just_i | input | 1 | Result format: 0 left, 1 right |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the done flag |
| int_clk_i | input | 1 | Free-running internal conversion clock |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code_o | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Acquisition (track) enable for the sample-and-hold |
| go_o | output | 1 | Go/done bit readback |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |
| done_flag_o | output | 1 | Sticky conversion-complete flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong trial mask or decision register shows up as a wrong result byte pair on the first completion. The bench sweeps input codes that exercise every bit: all zeros, all ones, and the two codes either side of mid-scale. A wrong divider decode or a wrong tick phase changes how long go_o stays high, and the bench measures that length exactly for each select code. A wrong sequencer state shows up at sample_o within one quiet period, or as a lost pending start, or as a result that changes after an abort.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_QUIET = 2'd2
  } sar_state_e;

  // Divider terminal count: period = 2^(1 + sel[2] + 2*sel[1:0])
  function automatic logic [CNT_W-1:0] div_limit(logic [2:0] sel);
    int unsigned e;
    e = 1 + int'(sel[2]) + 2 * int'(sel[1:0]);
    if (e > 6) e = 6;
    return CNT_W'((1 << e) - 1);
  endfunction
endpackage

// File: rtl/sar_tick_gen.sv
`timescale 1ns/1ps
module sar_tick_gen
  import sar_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  input  logic       int_clk_i,
  output logic       tick_o
);
  logic [SYNC_N:0]   sync_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lim;
  logic              use_int, div_tick, int_tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-1:0], int_clk_i};

  assign int_tick = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign use_int  = &sel_i[1:0];
  assign lim      = div_limit(sel_i);
  assign div_tick = (cnt_q >= lim);

  // counter held at zero while idle so each conversion starts on a fixed phase
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || div_tick)  cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;

  assign tick_o = run_i & (use_int ? int_tick : div_tick);
endmodule

// File: rtl/sar_approx.sv
`timescale 1ns/1ps
module sar_approx #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic [RES_W-1:0] decided_o,
  output logic             last_o
);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] code_q, mask_q;

  assign decided_o = cmp_i ? code_q : (code_q & ~mask_q);
  assign last_o    = mask_q[0];
  assign code_o    = code_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      code_q <= MSB;
      mask_q <= MSB;
    end else if (step_i) begin
      code_q <= decided_o | (mask_q >> 1);
      mask_q <= mask_q >> 1;
    end
endmodule

// File: rtl/sar_result_fmt.sv
`timescale 1ns/1ps
module sar_result_fmt #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              right_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam int PAD = 2 * BYTE_W - RES_W;

  logic [2*BYTE_W-1:0] word;

  assign word = right_i ? {{PAD{1'b0}}, res_i} : {res_i, {PAD{1'b0}}};
  assign hi_o = word[2*BYTE_W-1:BYTE_W];
  assign lo_o = word[BYTE_W-1:0];
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_set_i,
  input  logic              go_clr_i,
  input  logic [2:0]        clk_sel_i,
  input  logic              right_just_i,
  input  logic              irq_en_i,
  input  logic              flag_clr_i,
  input  logic              int_clk_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              sample_o,
  output logic              go_o,
  output logic [BYTE_W-1:0] res_hi_o,
  output logic [BYTE_W-1:0] res_lo_o,
  output logic              done_flag_o,
  output logic              irq_o
);
  sar_state_e       state_q;
  logic             pend_q, qcnt_q, flag_q;
  logic [RES_W-1:0] res_q, decided;
  logic             tick, last, busy, start, step, finish;

  assign busy   = (state_q == ST_CONV);
  assign start  = (state_q == ST_IDLE) & (go_set_i | pend_q) & ~go_clr_i;
  assign step   = busy & tick & ~go_clr_i;
  assign finish = step & last;

  sar_tick_gen u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q != ST_IDLE),
    .sel_i    (clk_sel_i),
    .int_clk_i(int_clk_i),
    .tick_o   (tick)
  );

  sar_approx #(.RES_W(RES_W)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .step_i   (step),
    .cmp_i    (cmp_i),
    .code_o   (dac_code_o),
    .decided_o(decided),
    .last_o   (last)
  );

  sar_result_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
    .res_i  (res_q),
    .right_i(right_just_i),
    .hi_o   (res_hi_o),
    .lo_o   (res_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      qcnt_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (start) state_q <= ST_CONV;
        end
        ST_CONV: begin
          if (go_clr_i) begin
            state_q <= ST_QUIET;
            qcnt_q  <= 1'b0;
          end else if (finish) begin
            state_q <= ST_QUIET;
            qcnt_q  <= 1'b0;
            res_q   <= decided;
          end
        end
        ST_QUIET: begin
          if (go_clr_i)      pend_q <= 1'b0;
          else if (go_set_i) pend_q <= 1'b1;
          if (tick) begin
            qcnt_q <= ~qcnt_q;
            if (qcnt_q) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         flag_q <= 1'b0;
    else if (finish)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;

  assign sample_o    = (state_q == ST_IDLE);
  assign go_o        = busy | pend_q;
  assign done_flag_o = flag_q;
  assign irq_o       = flag_q & irq_en_i;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
`timescale 1ns/1ps
module sar_conv_ctrl_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              go_clr_i,
  input logic              flag_clr_i,
  input logic              irq_en_i,
  input logic              right_just_i,
  input logic              busy_i,
  input logic              finish_i,
  input logic [RES_W-1:0]  res_i,
  input logic [BYTE_W-1:0] res_hi_o,
  input logic [BYTE_W-1:0] res_lo_o,
  input logic              sample_o,
  input logic              go_o,
  input logic              done_flag_o,
  input logic              irq_o
);
  localparam int PAD = 2 * BYTE_W - RES_W;

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_flag_o && irq_en_i));

  // R6
  finish_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_i |=> (done_flag_o && !go_o));

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !finish_i) |=> !done_flag_o);

  // R8
  abort_keeps_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && go_clr_i) |=> (res_i == $past(res_i)));

  // R9
  no_track_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !busy_i);

  // R11
  left_pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !right_just_i |-> (res_lo_o[PAD-1:0] == '0));

  // R12
  right_pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_just_i |-> (res_hi_o[BYTE_W-1:BYTE_W-PAD] == '0));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .go_clr_i    (go_clr_i),
  .flag_clr_i  (flag_clr_i),
  .irq_en_i    (irq_en_i),
  .right_just_i(right_just_i),
  .busy_i      (busy),
  .finish_i    (finish),
  .res_i       (res_q),
  .res_hi_o    (res_hi_o),
  .res_lo_o    (res_lo_o),
  .sample_o    (sample_o),
  .go_o        (go_o),
  .done_flag_o (done_flag_o),
  .irq_o       (irq_o)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
  logic       clk = 1'b0, rst_n = 1'b0, int_clk = 1'b0;
  logic       go_set = 0, go_clr = 0, rj = 0, irq_en = 0, flag_clr = 0;
  logic [2:0] sel = 3'b000;
  logic [9:0] vin = '0;
  logic [9:0] dac;
  logic       cmp, sample, go, flag, irq;
  logic [7:0] hi, lo;
  int         checks = 0, fails = 0, cycles = 0;

  always #4  clk = ~clk;
  always #40 int_clk = ~int_clk;

  assign cmp = (vin >= dac);

  sar_conv_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .go_set_i(go_set), .go_clr_i(go_clr),
    .clk_sel_i(sel), .right_just_i(rj), .irq_en_i(irq_en), .flag_clr_i(flag_clr),
    .int_clk_i(int_clk), .cmp_i(cmp), .dac_code_o(dac), .sample_o(sample),
    .go_o(go), .res_hi_o(hi), .res_lo_o(lo), .done_flag_o(flag), .irq_o(irq)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_fmt(string tag, logic [9:0] v);
    rj = 1'b0; #1;
    chk({tag, " R11 hi"}, int'(hi), int'(v[9:2]));
    chk({tag, " R11 lo"}, int'(lo), int'({v[1:0], 6'b0}));
    rj = 1'b1; #1;
    chk({tag, " R12 hi"}, int'(hi), int'({6'b0, v[9:8]}));
    chk({tag, " R12 lo"}, int'(lo), int'(v[7:0]));
    rj = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && !sample; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  // start, measure go_o high time in system cycles
  task automatic run_conv(logic [2:0] s, logic [9:0] v, output int dur);
    wait_idle();
    sel = s; vin = v;
    pulse_go();
    dur = 0;
    while (go && dur < 5000) begin
      dur++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 go", int'(go), 0);
    chk("R1 flag", int'(flag), 0);
    chk("R1 sample", int'(sample), 1);
    chk("R1 hi", int'(hi), 0);
    chk("R1 lo", int'(lo), 0);
  endtask

  task automatic t_start();
    wait_idle();
    sel = 3'b000; vin = 10'h100;
    pulse_go();
    chk("R2 go", int'(go), 1);
    chk("R2 sample", int'(sample), 0);
    while (go) @(negedge clk);
    clear_flag();
  endtask

  task automatic t_divisors();
    logic [2:0] codes [6] = '{3'b000, 3'b100, 3'b001, 3'b101, 3'b010, 3'b110};
    int         per   [6] = '{2, 4, 8, 16, 32, 64};
    int dur;
    for (int k = 0; k < 6; k++) begin
      run_conv(codes[k], 10'h2A5, dur);
      chk($sformatf("R3 duration sel=%b", codes[k]), dur, 10 * per[k]);
    end
    clear_flag();
  endtask

  task automatic t_results();
    logic [9:0] pats [5] = '{10'h000, 10'h3FF, 10'h200, 10'h1FF, 10'h0A6};
    int dur;
    for (int k = 0; k < 5; k++) begin
      run_conv(3'b000, pats[k], dur);
      chk_fmt($sformatf("R5 code %h", pats[k]), pats[k]);
    end
    clear_flag();
  endtask

  task automatic t_internal();
    int dur;
    run_conv(3'b011, 10'h2A5, dur);
    chk("R4 duration in range", int'(dur >= 85 && dur <= 105), 1);
    chk_fmt("R4 result", 10'h2A5);
    run_conv(3'b111, 10'h15A, dur);
    chk("R4 sel 111 result", int'(hi), int'(10'h15A >> 2));
    clear_flag();
  endtask

  task automatic t_flag_irq();
    int dur;
    irq_en = 1'b0;
    run_conv(3'b000, 10'h055, dur);
    chk("R6 go low", int'(go), 0);
    chk("R6 flag", int'(flag), 1);
    chk("R6 irq disabled", int'(irq), 0);
    irq_en = 1'b1; #1;
    chk("R6 irq enabled", int'(irq), 1);
    repeat (5) @(negedge clk);
    chk("R7 flag sticky", int'(flag), 1);
    clear_flag();
    chk("R7 flag cleared", int'(flag), 0);
    chk("R7 irq cleared", int'(irq), 0);
    irq_en = 1'b0;
  endtask

  task automatic t_abort();
    int dur, q;
    run_conv(3'b000, 10'h155, dur);
    clear_flag();
    wait_idle();
    vin = 10'h3FF;
    pulse_go();
    repeat (6) @(negedge clk);
    go_clr = 1'b1;
    @(negedge clk) go_clr = 1'b0;
    chk("R8 go low", int'(go), 0);
    chk("R9 quiet after abort", int'(sample), 0);
    q = 0;
    while (!sample && q < 100) begin q++; @(negedge clk); end
    chk("R9 abort quiet within 2 ticks", int'(q >= 1 && q <= 4), 1);
    chk("R8 flag not set", int'(flag), 0);
    chk_fmt("R8 result kept", 10'h155);
  endtask

  task automatic t_quiet();
    int dur, q;
    run_conv(3'b001, 10'h321, dur);
    q = 0;
    while (!sample && q < 500) begin q++; @(negedge clk); end
    chk("R9 quiet length", q, 16);
    repeat (20) @(negedge clk);
    chk("R9 tracking held", int'(sample), 1);
    clear_flag();
  endtask

  task automatic t_pending();
    int dur;
    run_conv(3'b000, 10'h111, dur);
    clear_flag();
    vin = 10'h2C3;
    go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
    chk("R10 go held", int'(go), 1);
    chk("R10 still quiet", int'(sample), 0);
    dur = 0;
    while (go && dur < 500) begin dur++; @(negedge clk); end
    chk("R10 pending conversion done", int'(flag), 1);
    chk_fmt("R10 result", 10'h2C3);
    clear_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_start();
    t_divisors();
    t_results();
    t_internal();
    t_flag_irq();
    t_abort();
    t_quiet();
    t_pending();
    summary();
  end
endmodule